// File: doc/BRIEF.md
# Floppy Controller Host State and Sense Logic

This block is the host-facing control core of an integrated floppy disk controller. It keeps eight single-bit control flags. The host changes one flag per access through a 16-location window. Address bits [3:1] pick the flag, and address bit 0 gives the value to store in it. Three of these flags select which of three views the read port shows: the data byte, a status byte, or the write-handshake byte.

The status byte carries a drive SENSE bit. That bit is picked from a set of drive condition inputs, using three phase flags and the head-select flag as the index. Most conditions read back inverted, so a true condition reads as 0. One of two drives feeds the condition inputs, chosen by a drive-select input.

A mode register sets the bit-cell length. A rising edge on the strobe flag issues a drive command (direction, step, motor on, eject), and each command appears as a one-cycle output pulse. Host writes go either to the data register or to the mode register, depending on the flags.

Top module: `fdc_host_ctrl`

## Requirements
- R1: An access with `acc_valid` high writes `acc_addr[0]` into the flag chosen by `acc_addr[3:1]` at the next clock edge. The flag order is: 0 = PH0, 1 = PH1, 2 = PH2, 3 = STRB, 4 = EN, 5 = HSEL, 6 = V6, 7 = V7.
- R2: `rd_data` is combinational from the current flags. V7=0, V6=0, EN=1 gives the data register. V7=0, V6=1 gives the status byte. V7=1, V6=0 gives the handshake byte. Every other combination gives 0xFF.
- R3: A `rd_strobe` while the data view is selected and data bit 7 is set clears the data register to 0x00 at that edge. A strobe with bit 7 clear leaves it unchanged.
- R4: Status byte layout: bit 7 = SENSE, bit 6 = 0, bit 5 = EN, bits 4:0 = mode register.
- R5: SENSE is indexed by {PH2,PH1,PH0,HSEL}. 0001 = not disk present. 0011 = write protected. 0100 = not motor running. 0101 = not at track 0. 0111 = not tach. 1100 = two heads. 1110 and 1111 = not installed. All other indices give 0.
- R6: `drive_sel` chooses which drive's condition inputs feed SENSE.
- R7: The handshake view reads 0xDF.
- R8: A `wr_strobe` with V7=1, V6=1, EN=0 loads `wr_data[4:0]` into the mode register. Mode bits [4:3]=10 set `cell_clocks` to 32, and 11 set it to 16. Any other value leaves `cell_clocks` unchanged.
- R9: A `wr_strobe` with V7=1, V6=1, EN=1 loads `wr_data` into the data register. This takes priority over a drive byte arriving in the same cycle.
- R10: An access that raises STRB from 0 to 1 decodes {PH1,PH0,HSEL}. 000 sets `step_dir` to PH2. 010 pulses `step_pulse`. 100 pulses `motor_pulse`. 110 pulses `eject_pulse`. Other codes do nothing. Each pulse lasts exactly one cycle, in the cycle after the edge.
- R11: After reset all flags are 0, the mode and data registers are 0, `cell_clocks` is 32, `step_dir` is 0 and no pulse is high.
- R12: `disk_byte_valid` loads `disk_byte` into the data register. A load in the same cycle as a clearing read wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Window access strobe |
| acc_addr | input | 4 | Window address: [3:1] flag, [0] value |
| rd_strobe | input | 1 | Host read of the current view (side effects only) |
| wr_strobe | input | 1 | Host write |
| wr_data | input | 8 | Host write byte |
| disk_byte_valid | input | 1 | Drive-side byte arrival |
| disk_byte | input | 8 | Drive-side byte |
| drive_sel | input | 1 | Drive whose conditions feed SENSE |
| drv_present | input | 2 | Disk in place, per drive |
| drv_wprot | input | 2 | Write protected, per drive |
| drv_motor | input | 2 | Motor running, per drive |
| drv_track0 | input | 2 | Head at track 0, per drive |
| drv_tach | input | 2 | Tachometer level, per drive |
| drv_two_heads | input | 2 | Double-sided drive, per drive |
| drv_installed | input | 2 | Drive installed, per drive |
| rd_data | output | 8 | Current read view |
| cell_clocks | output | 6 | Clocks per bit cell |
| step_dir | output | 1 | Step direction |
| step_pulse | output | 1 | Step command pulse |
| motor_pulse | output | 1 | Motor-on command pulse |
| eject_pulse | output | 1 | Eject command pulse |

## Verification
The read view is combinational, so the bench compares `rd_data` after inputs settle in the same cycle they are driven, before the edge. It reflects flags and registers updated at the previous edge. Flag, mode, data, `cell_clocks`, `step_dir` and the command pulses all change at the edge that takes the stimulus. The bench samples them 1 ns after that edge, and expects a pulse to be gone one cycle later. A lockstep model in the bench advances at each edge with the same inputs. Directed sweeps of every SENSE index for both drives and every STRB code come first, then seeded random traffic.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    // Flag vector; bit position equals the window index acc_addr[3:1].
    typedef struct packed {
        logic v7;
        logic v6;
        logic hsel;
        logic en;
        logic strb;
        logic ph2;
        logic ph1;
        logic ph0;
    } ctl_flags_t;

    localparam int unsigned FLAG_COUNT = 8;
    localparam int unsigned FLAG_IDX_W = $clog2(FLAG_COUNT);
    localparam logic [FLAG_IDX_W-1:0] IDX_STRB = 3'd3;

    typedef enum logic [1:0] {
        VIEW_DATA,
        VIEW_STATUS,
        VIEW_HSHAKE,
        VIEW_NONE
    } read_view_e;

    typedef struct packed {
        logic present;
        logic wprot;
        logic motor;
        logic track0;
        logic tach;
        logic two_heads;
        logic installed;
    } drive_cond_t;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_DIR,
        CMD_STEP,
        CMD_MOTOR,
        CMD_EJECT
    } drive_cmd_e;

    localparam logic [7:0] HSHAKE_BYTE = 8'hDF;
    localparam logic [7:0] OPEN_BYTE   = 8'hFF;
    localparam int unsigned MODE_W     = 5;

    function automatic read_view_e pick_view(input ctl_flags_t f);
        read_view_e v;
        case ({f.v7, f.v6})
            2'b00:   v = f.en ? VIEW_DATA : VIEW_NONE;
            2'b01:   v = VIEW_STATUS;
            2'b10:   v = VIEW_HSHAKE;
            default: v = VIEW_NONE;
        endcase
        return v;
    endfunction

    function automatic logic sense_of(input logic [3:0] idx, input drive_cond_t c);
        logic s;
        case (idx)
            4'b0001: s = ~c.present;
            4'b0011: s =  c.wprot;
            4'b0100: s = ~c.motor;
            4'b0101: s = ~c.track0;
            4'b0111: s = ~c.tach;
            4'b1100: s =  c.two_heads;
            4'b1110,
            4'b1111: s = ~c.installed;
            default: s = 1'b0;
        endcase
        return s;
    endfunction

    function automatic drive_cmd_e cmd_of(input ctl_flags_t f);
        drive_cmd_e c;
        case ({f.ph1, f.ph0, f.hsel})
            3'b000:  c = CMD_DIR;
            3'b010:  c = CMD_STEP;
            3'b100:  c = CMD_MOTOR;
            3'b110:  c = CMD_EJECT;
            default: c = CMD_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fdc_flag_bank.sv
module fdc_flag_bank
    import fdc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic [FLAG_IDX_W:0]   acc_addr,
    output ctl_flags_t            flags,
    output logic                  strb_rise
);
    logic [FLAG_COUNT-1:0] bits_q;

    for (genvar i = 0; i < FLAG_COUNT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[i] <= 1'b0;
            end else if (acc_valid && acc_addr[FLAG_IDX_W:1] == FLAG_IDX_W'(i)) begin
                bits_q[i] <= acc_addr[0];
            end
        end
    end

    assign flags     = ctl_flags_t'(bits_q);
    assign strb_rise = acc_valid && (acc_addr[FLAG_IDX_W:1] == IDX_STRB)
                       && acc_addr[0] && !bits_q[IDX_STRB];
endmodule

// File: rtl/fdc_sense_sel.sv
module fdc_sense_sel
    import fdc_pkg::*;
#(
    parameter int unsigned NUM_DRIVES = 2,
    localparam int unsigned SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
)(
    input  ctl_flags_t            flags,
    input  logic [SEL_W-1:0]      drive_sel,
    input  logic [NUM_DRIVES-1:0] drv_present,
    input  logic [NUM_DRIVES-1:0] drv_wprot,
    input  logic [NUM_DRIVES-1:0] drv_motor,
    input  logic [NUM_DRIVES-1:0] drv_track0,
    input  logic [NUM_DRIVES-1:0] drv_tach,
    input  logic [NUM_DRIVES-1:0] drv_two_heads,
    input  logic [NUM_DRIVES-1:0] drv_installed,
    output logic                  sense
);
    drive_cond_t conds [NUM_DRIVES];
    drive_cond_t chosen;

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        assign conds[d] = '{present:   drv_present[d],
                            wprot:     drv_wprot[d],
                            motor:     drv_motor[d],
                            track0:    drv_track0[d],
                            tach:      drv_tach[d],
                            two_heads: drv_two_heads[d],
                            installed: drv_installed[d]};
    end

    always_comb begin
        chosen = conds[0];
        for (int d = 0; d < NUM_DRIVES; d++) begin
            if (drive_sel == SEL_W'(d)) chosen = conds[d];
        end
    end

    assign sense = sense_of({flags.ph2, flags.ph1, flags.ph0, flags.hsel}, chosen);
endmodule

// File: rtl/fdc_cmd_pulse.sv
module fdc_cmd_pulse
    import fdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strb_rise,
    input  ctl_flags_t flags,
    output logic       step_dir,
    output logic       step_pulse,
    output logic       motor_pulse,
    output logic       eject_pulse
);
    drive_cmd_e cmd;

    always_comb begin
        cmd = strb_rise ? cmd_of(flags) : CMD_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_dir    <= 1'b0;
            step_pulse  <= 1'b0;
            motor_pulse <= 1'b0;
            eject_pulse <= 1'b0;
        end else begin
            step_pulse  <= (cmd == CMD_STEP);
            motor_pulse <= (cmd == CMD_MOTOR);
            eject_pulse <= (cmd == CMD_EJECT);
            if (cmd == CMD_DIR) step_dir <= flags.ph2;
        end
    end
endmodule

// File: rtl/fdc_regs.sv
module fdc_regs
    import fdc_pkg::*;
#(
    parameter int unsigned SLOW_CELL = 32,
    parameter int unsigned FAST_CELL = 16,
    localparam int unsigned CELL_W = $clog2(SLOW_CELL + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  ctl_flags_t        flags,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    input  logic [7:0]        wr_data,
    input  logic              disk_byte_valid,
    input  logic [7:0]        disk_byte,
    output logic [MODE_W-1:0] mode_q,
    output logic [7:0]        data_q,
    output logic [CELL_W-1:0] cell_clocks
);
    logic wr_mode, wr_data_reg, rd_clear;

    assign wr_mode     = wr_strobe && flags.v7 && flags.v6 && !flags.en;
    assign wr_data_reg = wr_strobe && flags.v7 && flags.v6 &&  flags.en;
    assign rd_clear    = rd_strobe && (pick_view(flags) == VIEW_DATA) && data_q[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            cell_clocks <= CELL_W'(SLOW_CELL);
        end else if (wr_mode) begin
            mode_q <= wr_data[MODE_W-1:0];
            case (wr_data[4:3])
                2'b10:   cell_clocks <= CELL_W'(SLOW_CELL);
                2'b11:   cell_clocks <= CELL_W'(FAST_CELL);
                default: cell_clocks <= cell_clocks;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (wr_data_reg) begin
            data_q <= wr_data;
        end else if (disk_byte_valid) begin
            data_q <= disk_byte;
        end else if (rd_clear) begin
            data_q <= '0;
        end
    end
endmodule

// File: rtl/fdc_host_ctrl.sv
module fdc_host_ctrl
    import fdc_pkg::*;
#(
    parameter int unsigned NUM_DRIVES = 2,
    parameter int unsigned SLOW_CELL  = 32,
    parameter int unsigned FAST_CELL  = 16,
    localparam int unsigned SEL_W  = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
    localparam int unsigned CELL_W = $clog2(SLOW_CELL + 1)
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic [3:0]            acc_addr,
    input  logic                  rd_strobe,
    input  logic                  wr_strobe,
    input  logic [7:0]            wr_data,
    input  logic                  disk_byte_valid,
    input  logic [7:0]            disk_byte,
    input  logic [SEL_W-1:0]      drive_sel,
    input  logic [NUM_DRIVES-1:0] drv_present,
    input  logic [NUM_DRIVES-1:0] drv_wprot,
    input  logic [NUM_DRIVES-1:0] drv_motor,
    input  logic [NUM_DRIVES-1:0] drv_track0,
    input  logic [NUM_DRIVES-1:0] drv_tach,
    input  logic [NUM_DRIVES-1:0] drv_two_heads,
    input  logic [NUM_DRIVES-1:0] drv_installed,
    output logic [7:0]            rd_data,
    output logic [CELL_W-1:0]     cell_clocks,
    output logic                  step_dir,
    output logic                  step_pulse,
    output logic                  motor_pulse,
    output logic                  eject_pulse
);
    ctl_flags_t        flags;
    logic              strb_rise;
    logic              sense;
    logic [MODE_W-1:0] mode_q;
    logic [7:0]        data_q;

    fdc_flag_bank u_flags (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .flags     (flags),
        .strb_rise (strb_rise)
    );

    fdc_sense_sel #(.NUM_DRIVES(NUM_DRIVES)) u_sense (
        .flags         (flags),
        .drive_sel     (drive_sel),
        .drv_present   (drv_present),
        .drv_wprot     (drv_wprot),
        .drv_motor     (drv_motor),
        .drv_track0    (drv_track0),
        .drv_tach      (drv_tach),
        .drv_two_heads (drv_two_heads),
        .drv_installed (drv_installed),
        .sense         (sense)
    );

    fdc_cmd_pulse u_cmd (
        .clk         (clk),
        .rst         (rst),
        .strb_rise   (strb_rise),
        .flags       (flags),
        .step_dir    (step_dir),
        .step_pulse  (step_pulse),
        .motor_pulse (motor_pulse),
        .eject_pulse (eject_pulse)
    );

    fdc_regs #(.SLOW_CELL(SLOW_CELL), .FAST_CELL(FAST_CELL)) u_regs (
        .clk             (clk),
        .rst             (rst),
        .flags           (flags),
        .rd_strobe       (rd_strobe),
        .wr_strobe       (wr_strobe),
        .wr_data         (wr_data),
        .disk_byte_valid (disk_byte_valid),
        .disk_byte       (disk_byte),
        .mode_q          (mode_q),
        .data_q          (data_q),
        .cell_clocks     (cell_clocks)
    );

    always_comb begin
        case (pick_view(flags))
            VIEW_DATA:   rd_data = data_q;
            VIEW_STATUS: rd_data = {sense, 1'b0, flags.en, mode_q};
            VIEW_HSHAKE: rd_data = HSHAKE_BYTE;
            default:     rd_data = OPEN_BYTE;
        endcase
    end
endmodule

// File: rtl/fdc_host_ctrl_chk.sv
module fdc_host_ctrl_chk
    import fdc_pkg::*;
#(
    parameter int unsigned SLOW_CELL = 32,
    parameter int unsigned FAST_CELL = 16,
    localparam int unsigned CELL_W = $clog2(SLOW_CELL + 1)
)(
    input logic              clk,
    input logic              rst,
    input ctl_flags_t        flags,
    input logic [7:0]        data_q,
    input logic [7:0]        rd_data,
    input logic              rd_strobe,
    input logic              wr_strobe,
    input logic              disk_byte_valid,
    input logic [CELL_W-1:0] cell_clocks,
    input logic              step_pulse,
    input logic              motor_pulse,
    input logic              eject_pulse
);
    AST_OPEN_VIEW: assert property (@(posedge clk) disable iff (rst)
        (flags.v7 && flags.v6) |-> rd_data == OPEN_BYTE); // R2

    AST_HSHAKE_VALUE: assert property (@(posedge clk) disable iff (rst)
        (flags.v7 && !flags.v6) |-> rd_data == HSHAKE_BYTE); // R7

    AST_DATA_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !flags.v7 && !flags.v6 && flags.en && rd_data[7]
         && !disk_byte_valid && !wr_strobe) |=> data_q == 8'h00); // R3

    AST_CELL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cell_clocks == CELL_W'(SLOW_CELL)) || (cell_clocks == CELL_W'(FAST_CELL))); // R8

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_pulse, motor_pulse, eject_pulse})); // R10

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse); // R10

    AST_STATUS_EN: assert property (@(posedge clk) disable iff (rst)
        (!flags.v7 && flags.v6) |-> (rd_data[5] == flags.en && !rd_data[6])); // R4
endmodule

bind fdc_host_ctrl fdc_host_ctrl_chk #(.SLOW_CELL(SLOW_CELL), .FAST_CELL(FAST_CELL)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .flags           (flags),
    .data_q          (data_q),
    .rd_data         (rd_data),
    .rd_strobe       (rd_strobe),
    .wr_strobe       (wr_strobe),
    .disk_byte_valid (disk_byte_valid),
    .cell_clocks     (cell_clocks),
    .step_pulse      (step_pulse),
    .motor_pulse     (motor_pulse),
    .eject_pulse     (eject_pulse)
);

// File: tb/fdc_host_ctrl_test.sv
`timescale 1ns/1ps
module fdc_host_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       acc_valid = 0;
    logic [3:0] acc_addr = 0;
    logic       rd_strobe = 0, wr_strobe = 0;
    logic [7:0] wr_data = 0;
    logic       disk_byte_valid = 0;
    logic [7:0] disk_byte = 0;
    logic       drive_sel = 0;
    logic [1:0] drv_present = 0, drv_wprot = 0, drv_motor = 0, drv_track0 = 0;
    logic [1:0] drv_tach = 0, drv_two_heads = 0, drv_installed = 0;
    logic [7:0] rd_data;
    logic [5:0] cell_clocks;
    logic       step_dir, step_pulse, motor_pulse, eject_pulse;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // bench model
    logic [7:0] m_fl;
    logic [4:0] m_mode;
    logic [7:0] m_data;
    int         m_cell;
    logic       m_dir;

    always #2 clk = ~clk;

    fdc_host_ctrl uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic m_sense();
        logic [3:0] idx = {m_fl[2], m_fl[1], m_fl[0], m_fl[5]};
        int d = drive_sel;
        case (idx)
            4'b0001: return !drv_present[d];
            4'b0011: return drv_wprot[d];
            4'b0100: return !drv_motor[d];
            4'b0101: return !drv_track0[d];
            4'b0111: return !drv_tach[d];
            4'b1100: return drv_two_heads[d];
            4'b1110, 4'b1111: return !drv_installed[d];
            default: return 1'b0;
        endcase
    endfunction

    // returns expected read byte and tag
    function automatic logic [7:0] m_read(output string tag);
        logic q7 = m_fl[7], q6 = m_fl[6], en = m_fl[4];
        if (!q7 && !q6 && en) begin tag = "R3"; return m_data; end
        if (!q7 && q6) begin tag = "R5"; return {m_sense(), 1'b0, en, m_mode}; end
        if (q7 && !q6) begin tag = "R7"; return 8'hDF; end
        tag = "R2";
        return 8'hFF;
    endfunction

    task automatic cyc(input logic av, input logic [3:0] ad, input logic rs,
                       input logic ws, input logic [7:0] wd,
                       input logic dv, input logic [7:0] db);
        string tag;
        logic [7:0] exp_rd;
        bit e_step, e_mot, e_ej, rise;
        logic [2:0] code;
        @(negedge clk);
        acc_valid = av; acc_addr = ad; rd_strobe = rs; wr_strobe = ws;
        wr_data = wd; disk_byte_valid = dv; disk_byte = db;
        #1;
        exp_rd = m_read(tag);
        chk(rd_data == exp_rd, tag, rd_data, exp_rd);
        rise = av && ad[3:1] == 3'd3 && ad[0] && !m_fl[3];
        code = {m_fl[1], m_fl[0], m_fl[5]};
        e_step = rise && code == 3'b010;
        e_mot  = rise && code == 3'b100;
        e_ej   = rise && code == 3'b110;
        if (rise && code == 3'b000) m_dir = m_fl[2];
        if (ws && m_fl[7] && m_fl[6] && !m_fl[4]) begin
            m_mode = wd[4:0];
            if (wd[4:3] == 2'b10) m_cell = 32;
            else if (wd[4:3] == 2'b11) m_cell = 16;
        end
        if (ws && m_fl[7] && m_fl[6] && m_fl[4]) m_data = wd;           // R9
        else if (dv) m_data = db;                                      // R12
        else if (rs && !m_fl[7] && !m_fl[6] && m_fl[4] && m_data[7]) m_data = 0;
        if (av) m_fl[ad[3:1]] = ad[0];                                 // R1
        @(posedge clk); #1;
        chk({step_pulse, motor_pulse, eject_pulse} == {e_step, e_mot, e_ej}, "R10",
            {step_pulse, motor_pulse, eject_pulse}, {e_step, e_mot, e_ej});
        chk(step_dir == m_dir, "R10", step_dir, m_dir);
        chk(cell_clocks == m_cell, "R8", cell_clocks, m_cell);
        acc_valid = 0; rd_strobe = 0; wr_strobe = 0; disk_byte_valid = 0;
    endtask

    task automatic setf(input int idx, input logic v);
        cyc(1, {idx[2:0], v}, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        rst = 1;
        m_fl = 0; m_mode = 0; m_data = 0; m_cell = 32; m_dir = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R11 reset state
        chk(rd_data == 8'hFF, "R11", rd_data, 8'hFF);
        chk(cell_clocks == 32, "R11", cell_clocks, 32);
        chk({step_dir, step_pulse, motor_pulse, eject_pulse} == 0, "R11",
            {step_dir, step_pulse, motor_pulse, eject_pulse}, 0);

        // R5 / R6: sweep all sense indices, both drives, two condition patterns
        setf(6, 1);                              // V6=1 -> status view
        for (int pat = 0; pat < 2; pat++) begin
            {drv_present, drv_wprot, drv_motor, drv_track0} = pat ? 8'b01100110 : 8'b10011001;
            {drv_tach, drv_two_heads, drv_installed} = pat ? 6'b011001 : 6'b100110;
            for (int d = 0; d < 2; d++) begin
                drive_sel = d[0];
                for (int i = 0; i < 16; i++) begin
                    setf(2, i[3]); setf(1, i[2]); setf(0, i[1]); setf(5, i[0]);
                end
            end
        end

        // R8 mode writes
        setf(6, 1); setf(7, 1); setf(4, 0);
        cyc(0, 0, 0, 1, 8'h18, 0, 0);
        chk(cell_clocks == 16, "R8", cell_clocks, 16);
        cyc(0, 0, 0, 1, 8'h05, 0, 0);
        chk(cell_clocks == 16, "R8", cell_clocks, 16);
        cyc(0, 0, 0, 1, 8'h17, 0, 0);
        chk(cell_clocks == 32, "R8", cell_clocks, 32);
        setf(7, 0);                              // status: R4 mode echo
        chk(rd_data[4:0] == 5'h17, "R4", rd_data[4:0], 5'h17);

        // R9 host write to data, R3 clear on read
        setf(6, 1); setf(7, 1); setf(4, 1);
        cyc(0, 0, 0, 1, 8'hA5, 1, 8'h33);        // host wins over disk byte
        setf(7, 0); setf(6, 0);
        chk(rd_data == 8'hA5, "R9", rd_data, 8'hA5);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk(rd_data == 8'h00, "R3", rd_data, 8'h00);
        cyc(0, 0, 0, 0, 0, 1, 8'h45);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk(rd_data == 8'h45, "R3", rd_data, 8'h45);
        cyc(0, 0, 1, 0, 0, 1, 8'h9C);            // R12 load beats clear
        chk(rd_data == 8'h9C, "R12", rd_data, 8'h9C);

        // R10 every strobe code
        for (int c = 0; c < 16; c++) begin
            setf(2, c[3]); setf(1, c[2]); setf(0, c[1]); setf(5, c[0]);
            setf(3, 1); setf(3, 1); setf(3, 0);
        end

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            drive_sel = 1'($urandom);
            {drv_present, drv_wprot, drv_motor, drv_track0} = 8'($urandom);
            {drv_tach, drv_two_heads, drv_installed} = 6'($urandom);
            cyc(($urandom % 3) != 0, 4'($urandom), 1'($urandom), ($urandom % 4) == 0,
                8'($urandom), ($urandom % 5) == 0, 8'($urandom));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule